// File: doc/BRIEF.md
# Control-Register Bit-Field Insert Unit

This combinational execute-stage unit merges a field of a source operand into a target operand. The field's starting bit and its width do not come from the instruction. They are read from fields of a control register value that the pipeline supplies. Bits of the source inside the field replace the same bits of the target. All other target bits are kept.

Two variants share the datapath:
- The narrow variant works on the low 32 bits and sign-extends its result to 64 bits.
- The wide variant works on all 64 bits and reads wider position and size fields.

The unit also decodes the minor function and sub-op fields and checks the mode and the DSP-enable flag. From these it produces a register write-enable and two exception flags.

Top module: `ctl_field_insert`

## Requirements
- R1: Narrow variant (func = 6'h0C): position = ctl_reg[4:0] and size = ctl_reg[11:7]. The field covers bits pos to pos+size-1. In result[31:0], bits inside the field come from src_val and bits outside come from dst_val. Field bits above 31 are dropped. result[63:32] copies result[31]. All other ctl_reg bits have no effect.
- R2: Wide variant (func = 6'h0D): position = ctl_reg[6:0] and size = ctl_reg[12:7]. The merge covers all 64 bits. Field bits at index 64 or above are dropped.
- R3: If size is zero, result equals dst_val exactly, in both variants. The narrow variant does not sign-extend in this case.
- R4: If pos+size-1 is greater than 64, result equals dst_val exactly.
- R5: A destination index of zero never asserts wr_en.
- R6: If func selects a variant and sub_op is not zero, rsvd_exc is raised and wr_en stays low.
- R7: The wide variant with mode64 low raises rsvd_exc and does not write. The narrow variant is legal in either mode.
- R8: A legal instruction with dsp_en low raises dsp_exc and does not write. The narrow variant does this even when the index is zero. For the wide variant, an index of zero suppresses dsp_exc. rsvd_exc has priority over dsp_exc.
- R9: Any other func value gives no write and no exception.
- R10: A legal, enabled instruction with a nonzero index asserts wr_en, and no exception flag is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_val | input | 64 | Operand that supplies the field bits |
| dst_val | input | 64 | Operand that is modified |
| ctl_reg | input | 32 | Control register holding the position and size fields |
| dst_idx | input | 5 | Destination register index |
| mode64 | input | 1 | Processor runs in 64-bit mode |
| dsp_en | input | 1 | DSP instructions enabled |
| func | input | 6 | Minor function field of the instruction |
| sub_op | input | 5 | Sub-op field of the instruction, bits 10:6 |
| result | output | 64 | Merged value |
| wr_en | output | 1 | Write result to dst_idx |
| rsvd_exc | output | 1 | Reserved-instruction exception |
| dsp_exc | output | 1 | DSP-disabled exception |

## Verification
The unit has no state, so any wrong mask or field decode shows on result in the same cycle as the inputs that expose it. An off-by-one in the range rule changes result only at the edges: size zero, and msb at 63, 64 and 65. The bench therefore sweeps every position and size pair of both variants. A slip in the exception decode shows as a wrong wr_en, rsvd_exc or dsp_exc for one specific mix of index, mode and enable. Each of those mixes is driven directly.

// File: rtl/ctl_field_insert.sv
module ctl_field_insert #(
  parameter int XLEN      = 64,
  parameter int HALF      = 32,
  parameter int CTL_W     = 32,
  parameter int NPOS_W    = 5,
  parameter int WPOS_W    = 7,
  parameter int NSZ_W     = 5,
  parameter int WSZ_W     = 6,
  parameter int SZ_LSB    = 7,
  parameter int IDX_W     = 5,
  parameter logic [5:0] FN_NARROW = 6'h0C,
  parameter logic [5:0] FN_WIDE   = 6'h0D
) (
  input  logic [XLEN-1:0]  src_val,
  input  logic [XLEN-1:0]  dst_val,
  input  logic [CTL_W-1:0] ctl_reg,
  input  logic [IDX_W-1:0] dst_idx,
  input  logic             mode64,
  input  logic             dsp_en,
  input  logic [5:0]       func,
  input  logic [4:0]       sub_op,
  output logic [XLEN-1:0]  result,
  output logic             wr_en,
  output logic             rsvd_exc,
  output logic             dsp_exc
);
  localparam int MW = XLEN + 1;
  localparam int CW = WPOS_W + 2;

  logic              is_n, is_w, sel, illegal, idx_nz;
  logic [WPOS_W-1:0] pos;
  logic [WSZ_W-1:0]  size;
  logic [CW-1:0]     top;
  logic              range_bad;
  logic [MW-1:0]     ones, mask;
  logic [XLEN-1:0]   merged, narrow_out;

  assign is_n   = (func == FN_NARROW);
  assign is_w   = (func == FN_WIDE);
  assign sel    = is_n | is_w;
  assign idx_nz = |dst_idx;

  assign pos  = is_w ? ctl_reg[WPOS_W-1:0] : WPOS_W'(ctl_reg[NPOS_W-1:0]);
  assign size = is_w ? ctl_reg[SZ_LSB +: WSZ_W] : WSZ_W'(ctl_reg[SZ_LSB +: NSZ_W]);

  assign top       = CW'(pos) + CW'(size);
  assign range_bad = (size == '0) || (top > CW'(XLEN + 1));

  assign ones   = (MW'(1) << size) - MW'(1);
  assign mask   = ones << pos;
  assign merged = (src_val & mask[XLEN-1:0]) | (dst_val & ~mask[XLEN-1:0]);
  assign narrow_out = {{(XLEN-HALF){merged[HALF-1]}}, merged[HALF-1:0]};

  assign result = range_bad ? dst_val : (is_w ? merged : narrow_out);

  assign illegal  = sel & ((sub_op != 5'd0) | (is_w & ~mode64));
  assign rsvd_exc = illegal;
  assign dsp_exc  = sel & ~illegal & ~dsp_en & (is_n | idx_nz);
  assign wr_en    = sel & ~illegal & dsp_en & idx_nz;

  always_comb begin
    if (dst_idx == '0) AST_NO_ZERO_WRITE: assert (!wr_en);                       // R5
    AST_EXC_EXCLUSIVE: assert (!(rsvd_exc && dsp_exc));                           // R8
    if (wr_en) AST_WRITE_CLEAN: assert (!rsvd_exc && !dsp_exc);                   // R10
    if (!is_n && !is_w) AST_FOREIGN_QUIET: assert (!wr_en && !rsvd_exc && !dsp_exc); // R9
    if (sub_op != 5'd0) AST_SUBOP_NO_WRITE: assert (!wr_en);                     // R6
    if (is_w && !mode64) AST_WIDE_NEEDS_64: assert (!wr_en);                     // R7
    if (size == '0) AST_EMPTY_KEEPS: assert (result == dst_val);                 // R3
    if (is_n && !range_bad)
      AST_NARROW_SEXT: assert (result[XLEN-1:HALF] == {(XLEN-HALF){result[HALF-1]}}); // R1
  end
endmodule

// File: tb/ctl_field_insert_bench.sv
module ctl_field_insert_bench;
  logic        clk = 1'b0;
  logic [63:0] src_val, dst_val, result;
  logic [31:0] ctl_reg;
  logic [4:0]  dst_idx, sub_op;
  logic        mode64, dsp_en, wr_en, rsvd_exc, dsp_exc;
  logic [5:0]  func;
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  ctl_field_insert u_ctl_field_insert (
    .src_val(src_val), .dst_val(dst_val), .ctl_reg(ctl_reg), .dst_idx(dst_idx),
    .mode64(mode64), .dsp_en(dsp_en), .func(func), .sub_op(sub_op),
    .result(result), .wr_en(wr_en), .rsvd_exc(rsvd_exc), .dsp_exc(dsp_exc));

  function automatic logic [63:0] model(input bit narrow, input int p, input int s,
                                        input logic [63:0] a, input logic [63:0] b);
    logic [63:0] m, r;
    if (s == 0 || p + s - 1 > 64) return b;
    for (int i = 0; i < 64; i++) m[i] = (i >= p) && (i < p + s);
    r = (a & m) | (b & ~m);
    if (narrow) r = {{32{r[31]}}, r[31:0]};
    return r;
  endfunction

  task automatic chk64(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_ctl(input string tag, input logic w, input logic r, input logic d);
    checks++;
    if ({wr_en, rsvd_exc, dsp_exc} !== {w, r, d}) begin
      errors++;
      $display("FAIL %s actual we/rsvd/dsp=%b%b%b expected=%b%b%b",
               tag, wr_en, rsvd_exc, dsp_exc, w, r, d);
    end
  endtask

  task automatic apply(input logic [5:0] f, input logic [4:0] so, input logic [4:0] idx,
                       input logic m64, input logic en);
    @(posedge clk);
    func = f; sub_op = so; dst_idx = idx; mode64 = m64; dsp_en = en;
    @(negedge clk);
  endtask

  initial begin
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    src_val = 64'hA5C3_0F96_7E81_D24B; dst_val = 64'h1234_5678_9ABC_DEF0;
    ctl_reg = 32'h0000_0283; dst_idx = 5'd3; sub_op = 5'd0; mode64 = 1'b1;
    dsp_en = 1'b1; func = 6'h0C;
    @(negedge clk);
    chk_ctl("R10 initial legal narrow", 1'b1, 1'b0, 1'b0);

    // R1 R3: narrow sweep, junk in unused control bits
    for (int p = 0; p < 32; p++) begin
      for (int s = 0; s < 32; s++) begin
        @(posedge clk);
        func = 6'h0C;
        src_val = 64'hA5C3_0F96_7E81_D24B ^ 64'(p * 97 + s * 13);
        dst_val = p[0] ? 64'h0123_4567_89AB_CDEF : 64'hFEDC_BA98_7654_3210;
        ctl_reg = 32'hFFFF_F060 | (32'(s) << 7) | 32'(p);
        @(negedge clk);
        chk64(s == 0 ? "R3 narrow size zero" : "R1 narrow insert", result,
              model(1'b1, p, s, src_val, dst_val));
      end
    end

    // R2 R3 R4: wide sweep
    for (int p = 0; p < 128; p++) begin
      for (int s = 0; s < 64; s++) begin
        @(posedge clk);
        func = 6'h0D;
        src_val = 64'h5A3C_F069_817E_2DB4 ^ 64'(p * 31 + s * 7);
        dst_val = s[0] ? 64'hC0DE_F00D_1357_9BDF : 64'h3F21_0ACE_8642_EC8A;
        ctl_reg = 32'hFFFF_E000 | (32'(s) << 7) | 32'(p);
        @(negedge clk);
        chk64(s == 0 ? "R3 wide size zero" : (p + s - 1 > 64 ? "R4 wide out of range" : "R2 wide insert"),
              result, model(1'b0, p, s, src_val, dst_val));
      end
    end

    // R4 boundary: msb 64 still valid, 65 invalid
    src_val = '1; dst_val = '0;
    @(posedge clk); ctl_reg = (32'd63 << 7) | 32'd2; @(negedge clk);
    chk64("R4 msb 64 valid", result, 64'hFFFF_FFFF_FFFF_FFFC);
    @(posedge clk); ctl_reg = (32'd63 << 7) | 32'd3; @(negedge clk);
    chk64("R4 msb 65 keeps target", result, 64'h0);

    apply(6'h0C, 5'd0, 5'd0, 1'b1, 1'b1);  chk_ctl("R5 narrow index zero", 1'b0, 1'b0, 1'b0);
    apply(6'h0D, 5'd0, 5'd0, 1'b1, 1'b1);  chk_ctl("R5 wide index zero", 1'b0, 1'b0, 1'b0);
    apply(6'h0C, 5'd1, 5'd7, 1'b1, 1'b1);  chk_ctl("R6 narrow sub-op", 1'b0, 1'b1, 1'b0);
    apply(6'h0D, 5'd16, 5'd7, 1'b1, 1'b1); chk_ctl("R6 wide sub-op", 1'b0, 1'b1, 1'b0);
    apply(6'h0D, 5'd0, 5'd7, 1'b0, 1'b1);  chk_ctl("R7 wide in 32-bit mode", 1'b0, 1'b1, 1'b0);
    apply(6'h0C, 5'd0, 5'd7, 1'b0, 1'b1);  chk_ctl("R7 narrow in 32-bit mode", 1'b1, 1'b0, 1'b0);
    apply(6'h0C, 5'd0, 5'd7, 1'b1, 1'b0);  chk_ctl("R8 narrow disabled", 1'b0, 1'b0, 1'b1);
    apply(6'h0C, 5'd0, 5'd0, 1'b1, 1'b0);  chk_ctl("R8 narrow disabled index zero", 1'b0, 1'b0, 1'b1);
    apply(6'h0D, 5'd0, 5'd0, 1'b1, 1'b0);  chk_ctl("R8 wide disabled index zero", 1'b0, 1'b0, 1'b0);
    apply(6'h0D, 5'd0, 5'd9, 1'b1, 1'b0);  chk_ctl("R8 wide disabled", 1'b0, 1'b0, 1'b1);
    apply(6'h0C, 5'd3, 5'd9, 1'b1, 1'b0);  chk_ctl("R8 reserved over disabled", 1'b0, 1'b1, 1'b0);
    apply(6'h0D, 5'd0, 5'd9, 1'b0, 1'b0);  chk_ctl("R8 mode over disabled", 1'b0, 1'b1, 1'b0);
    for (int f = 0; f < 64; f++) begin
      if (f != 12 && f != 13) begin
        apply(6'(f), 5'd1, 5'd9, 1'b0, 1'b0);
        chk_ctl("R9 foreign func", 1'b0, 1'b0, 1'b0);
      end
    end
    apply(6'h0D, 5'd0, 5'd31, 1'b1, 1'b1); chk_ctl("R10 wide legal", 1'b1, 1'b0, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule